// File: doc/BRIEF.md
# Vertical Scaler Line Selector

This block decides, one input line at a time, how the active lines of an incoming frame are gathered into output lines when an image is shrunk vertically. A scale setting in 4096ths defines the ratio: each output line covers one input line plus a fraction `vscale/4096` of another. A 12-bit phase accumulator carries the fractional remainder from one output line to the next, so groups of one, two or three input lines alternate to track the ratio. The first and the last active input lines of a frame each close an output line, whatever the accumulator says.

Every completed output line records the number of input lines it merged, and that number is written into a small slot queue. The output side takes slots from the queue at its own pace. The queue separates the two line rates. If it fills, or if the output side asks for a slot when none is there, a sticky flag is raised. Both flags stay set until the next start of frame.

Top module: `vss_line_select`

## Requirements
- R1: After reset, `emit`, `rd_valid`, `overrun` and `underrun` are all 0.
- R2: The first input line strobe accepted after a start of frame always completes an output line with merge count 1, and `emit_first` is high with it.
- R3: The phase starts at 0 on each start of frame. After each output line, the size of the next group is 1 + floor((phase + s)/4096), and the new phase is (phase + s) mod 4096. Here s is the effective scale. `emit_merge` gives the number of input lines, 1 to 3, in the completed line as a plain binary value.
- R4: A `vscale` value above 8191 acts as 8191, so no output line merges more than 3 input lines.
- R5: The strobe for active line `active_lines`-1, counted from 0, always completes an output line. Its merge count is the number of lines gathered so far, including that one, and `emit_last` is high with it.
- R6: A line strobe is ignored, with no emission and no change to the grouping, in two cases: once `active_lines` strobes have been accepted in the frame, or when it arrives in the same cycle as `sof`.
- R7: `emit`, `emit_merge`, `emit_first` and `emit_last` are valid for exactly one cycle, namely the cycle after the accepted strobe.
- R8: Each emission writes its merge count into the slot queue. An `out_req` while the queue is non-empty gives `rd_valid`=1 in the next cycle, with the oldest count on `rd_merge`, in first-in first-out order.
- R9: An emission that finds the queue full, with no slot taken in the same cycle, is dropped and sets `overrun`.
- R10: An `out_req` while the queue is empty leaves `rd_valid` at 0 and sets `underrun`.
- R11: `overrun` and `underrun` stay set until a start-of-frame cycle clears them. If a new event occurs in that same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof | input | 1 | Start of frame; restarts line count and phase, clears flags |
| line_stb | input | 1 | One-cycle pulse per input line |
| active_lines | input | LINE_W | Number of active input lines per frame |
| vscale | input | SCALE_W | Scale fraction in 4096ths |
| out_req | input | 1 | Output side takes one line slot |
| emit | output | 1 | An output line completed on the last accepted strobe |
| emit_merge | output | 2 | Input lines merged into that output line (1..3) |
| emit_first | output | 1 | The completed line is the frame's first |
| emit_last | output | 1 | The completed line is the frame's last |
| rd_valid | output | 1 | A slot was read on the previous request |
| rd_merge | output | 2 | Merge count of the slot read |
| overrun | output | 1 | Sticky: an emission was dropped on a full queue |
| underrun | output | 1 | Sticky: a request found the queue empty |

## Verification
On every cycle, the assertions check the following: the merge count stays within 1 to 3, emissions only follow an accepted strobe inside the active count, the first emission merges a single line, the flags are sticky, and the queue occupancy stays bounded. The exact group pattern depends on the accumulated phase for a given scale. The forced last line, the saturation above 8191, the slot order and the point at which the queue overflows or runs dry can only be shown by the bench. It sweeps many scale and line-count pairs and compares each result against counts worked out arithmetically.

// File: rtl/vss_pkg.sv
package vss_pkg;
    localparam int FRAC_W  = 12;
    localparam int SUM_W   = FRAC_W + 2;
    localparam int SAT_MAX = (1 << (FRAC_W + 1)) - 1;
    typedef logic [1:0] merge_t;
endpackage

// File: rtl/vss_ratio.sv
module vss_ratio
    import vss_pkg::*;
#(
    parameter int SCALE_W = 16
) (
    input  logic [FRAC_W-1:0]  acc_i,
    input  logic [SCALE_W-1:0] scale_i,
    output merge_t             need_o,
    output logic [FRAC_W-1:0]  acc_o
);
    logic [FRAC_W:0]  sat;
    logic [SUM_W-1:0] total;

    always_comb begin
        // saturate so that a group never exceeds three lines
        if (scale_i > SCALE_W'(SAT_MAX)) sat = '1;
        else                             sat = scale_i[FRAC_W:0];
        total  = SUM_W'(acc_i) + SUM_W'(sat);
        need_o = 2'd1 + total[SUM_W-1 -: 2];
        acc_o  = total[FRAC_W-1:0];
    end
endmodule

// File: rtl/vss_fifo.sv
module vss_fifo
    import vss_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push_i,
    input  merge_t data_i,
    input  logic   pop_i,
    output logic   full_o,
    output logic   empty_o,
    output logic   rd_valid_o,
    output merge_t rd_data_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        merge_t [DEPTH-1:0] mem;
        logic [PW-1:0]      wp;
        logic [PW-1:0]      rp;
        logic [CW-1:0]      cnt;
        logic               rv;
        merge_t             rd;
    } fifo_st_t;

    fifo_st_t f_d, f_q;
    logic do_pop, do_push;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        f_d     = f_q;
        f_d.rv  = 1'b0;
        do_pop  = pop_i && (f_q.cnt != '0);
        do_push = push_i && ((f_q.cnt != CW'(DEPTH)) || do_pop);
        if (do_pop) begin
            f_d.rd = f_q.mem[f_q.rp];
            f_d.rv = 1'b1;
            f_d.rp = wrap_inc(f_q.rp);
        end
        if (do_push) begin
            f_d.mem[f_q.wp] = data_i;
            f_d.wp          = wrap_inc(f_q.wp);
        end
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + CW'(1);
            2'b01:   f_d.cnt = f_q.cnt - CW'(1);
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign full_o     = (f_q.cnt == CW'(DEPTH));
    assign empty_o    = (f_q.cnt == '0);
    assign rd_valid_o = f_q.rv;
    assign rd_data_o  = f_q.rd;

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CW'(DEPTH));
    assert_read_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(pop_i));
endmodule

// File: rtl/vss_line_select.sv
module vss_line_select
    import vss_pkg::*;
#(
    parameter int LINE_W     = 12,
    parameter int SCALE_W    = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof,
    input  logic               line_stb,
    input  logic [LINE_W-1:0]  active_lines,
    input  logic [SCALE_W-1:0] vscale,
    input  logic               out_req,
    output logic               emit,
    output logic [1:0]         emit_merge,
    output logic               emit_first,
    output logic               emit_last,
    output logic               rd_valid,
    output logic [1:0]         rd_merge,
    output logic               overrun,
    output logic               underrun
);
    typedef struct packed {
        logic [LINE_W-1:0] idx;
        merge_t            gath;
        merge_t            need;
        logic [FRAC_W-1:0] acc;
        logic              emit;
        logic              first;
        logic              last;
        merge_t            merge;
        logic              ovr;
        logic              unr;
    } sel_st_t;

    sel_st_t           st_d, st_q;
    merge_t            need_nx, grown;
    logic [FRAC_W-1:0] acc_nx;
    logic              push, full, empty, is_last;

    vss_ratio #(.SCALE_W(SCALE_W)) u_ratio (
        .acc_i   (st_q.acc),
        .scale_i (vscale),
        .need_o  (need_nx),
        .acc_o   (acc_nx)
    );

    vss_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .data_i     (st_d.merge),
        .pop_i      (out_req),
        .full_o     (full),
        .empty_o    (empty),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_merge)
    );

    always_comb begin
        st_d       = st_q;
        st_d.emit  = 1'b0;
        st_d.first = 1'b0;
        st_d.last  = 1'b0;
        push       = 1'b0;
        grown      = st_q.gath + 2'd1;
        is_last    = (st_q.idx == active_lines - LINE_W'(1));
        if (sof) begin
            st_d.idx  = '0;
            st_d.gath = '0;
            st_d.need = 2'd1;
            st_d.acc  = '0;
            st_d.ovr  = 1'b0;
            st_d.unr  = 1'b0;
        end else if (line_stb && (st_q.idx < active_lines)) begin
            if ((grown == st_q.need) || is_last) begin
                st_d.emit  = 1'b1;
                st_d.merge = grown;
                st_d.first = (st_q.idx == '0);
                st_d.last  = is_last;
                st_d.gath  = '0;
                st_d.need  = need_nx;
                st_d.acc   = acc_nx;
                push       = 1'b1;
            end else begin
                st_d.gath = grown;
            end
            st_d.idx = st_q.idx + LINE_W'(1);
        end
        if (push && full && !out_req) st_d.ovr = 1'b1;
        if (out_req && empty)         st_d.unr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.need <= 2'd1;
        end else begin
            st_q <= st_d;
        end
    end

    assign emit       = st_q.emit;
    assign emit_merge = st_q.merge;
    assign emit_first = st_q.first;
    assign emit_last  = st_q.last;
    assign overrun    = st_q.ovr;
    assign underrun   = st_q.unr;

    assert_emit_after_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> $past(line_stb && !sof));
    assert_merge_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (emit_merge >= 2'd1 && emit_merge <= 2'd3));
    assert_first_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        emit_first |-> (emit && emit_merge == 2'd1));
    assert_inside_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> $past(st_q.idx < active_lines));
    assert_ovr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !sof) |=> overrun);
    assert_unr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !sof) |=> underrun);
endmodule

// File: tb/vss_line_select_bench.sv
`timescale 1ns/1ps
module vss_line_select_bench;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0;
    logic        line_stb = 1'b0;
    logic [11:0] active_lines = '0;
    logic [15:0] vscale = '0;
    logic        out_req = 1'b0;
    logic        emit, emit_first, emit_last, rd_valid, overrun, underrun;
    logic [1:0]  emit_merge, rd_merge;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int m_idx, m_gath, m_need, m_acc, m_act, m_scale;
    int q[64];
    int qh, qn;
    bit x_ovr, x_unr;

    always #2.5 clk = ~clk;

    vss_line_select u_vss_line_select (
        .clk(clk), .rst_n(rst_n), .sof(sof), .line_stb(line_stb),
        .active_lines(active_lines), .vscale(vscale), .out_req(out_req),
        .emit(emit), .emit_merge(emit_merge), .emit_first(emit_first),
        .emit_last(emit_last), .rd_valid(rd_valid), .rd_merge(rd_merge),
        .overrun(overrun), .underrun(underrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic start_frame(input int act, input int scale);
        @(negedge clk);
        sof = 1'b1;
        active_lines = 12'(act);
        vscale = 16'(scale);
        @(negedge clk);
        sof = 1'b0;
        m_idx = 0; m_gath = 0; m_need = 1; m_acc = 0;
        m_act = act; m_scale = scale;
        x_ovr = 0; x_unr = 0;
        chk("R11 overrun cleared", int'(overrun), 0);
        chk("R11 underrun cleared", int'(underrun), 0);
    endtask

    task automatic pop_chk();
        int e_v, e_d;
        e_v = (qn > 0) ? 1 : 0;
        e_d = (qn > 0) ? q[qh] : 0;
        if (qn > 0) begin qh = (qh + 1) % 64; qn--; end
        else x_unr = 1;
        @(negedge clk);
        out_req = 1'b1;
        @(negedge clk);
        out_req = 1'b0;
        if (e_v == 1) begin
            chk("R8 rd_valid", int'(rd_valid), 1);
            chk("R8 rd_merge order", int'(rd_merge), e_d);
        end else begin
            chk("R10 rd_valid on empty", int'(rd_valid), 0);
        end
        chk("R10 underrun flag", int'(underrun), int'(x_unr));
    endtask

    task automatic do_line(input bit pop_after);
        int e_emit, e_m, e_f, e_l, g, sat, tot;
        e_emit = 0; e_m = 0; e_f = 0; e_l = 0;
        if (m_idx < m_act) begin
            g = m_gath + 1;
            if (g == m_need || m_idx == m_act - 1) begin
                e_emit = 1; e_m = g;
                e_f = (m_idx == 0) ? 1 : 0;
                e_l = (m_idx == m_act - 1) ? 1 : 0;
                sat = (m_scale > 8191) ? 8191 : m_scale;
                tot = m_acc + sat;
                m_need = 1 + tot / 4096;
                m_acc = tot % 4096;
                m_gath = 0;
                if (qn < DEPTH) begin q[(qh + qn) % 64] = e_m; qn++; end
                else x_ovr = 1;
            end else begin
                m_gath = g;
            end
            m_idx++;
        end
        @(negedge clk);
        line_stb = 1'b1;
        @(negedge clk);
        line_stb = 1'b0;
        if (e_emit == 0 && m_idx >= m_act && e_f == 0)
            chk("R6/R3 emit", int'(emit), 0);
        else
            chk("R3 emit", int'(emit), e_emit);
        if (e_emit == 1) begin
            chk("R3 merge count", int'(emit_merge), e_m);
            chk("R2 first flag", int'(emit_first), e_f);
            chk("R5 last flag", int'(emit_last), e_l);
            if (m_scale > 8191) chk("R4 merge within 3", int'(emit_merge <= 2'd3), 1);
        end
        @(negedge clk);
        chk("R7 emit one cycle", int'(emit), 0);
        chk("R9 overrun flag", int'(overrun), int'(x_ovr));
        if (pop_after && e_emit == 1) pop_chk();
    endtask

    initial begin
        int scales[9] = '{0, 1, 2048, 4095, 4096, 6000, 8191, 9000, 65535};
        int acts[5]   = '{1, 2, 5, 13, 40};
        qh = 0; qn = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 emit", int'(emit), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 underrun", int'(underrun), 0);

        foreach (scales[i]) begin
            foreach (acts[j]) begin
                start_frame(acts[j], scales[i]);
                for (int n = 0; n < acts[j] + 2; n++) do_line(1'b1);
                chk("R9 no overrun in paced frame", int'(overrun), 0);
                chk("R10 no underrun in paced frame", int'(underrun), 0);
            end
        end

        // R6: strobe coincident with sof is dropped
        start_frame(3, 0);
        @(negedge clk);
        sof = 1'b1; line_stb = 1'b1;
        @(negedge clk);
        sof = 1'b0; line_stb = 1'b0;
        chk("R6 strobe with sof ignored", int'(emit), 0);
        for (int n = 0; n < 3; n++) do_line(1'b1);

        // R9/R10/R11: fill without draining, then drain past empty
        start_frame(12, 4096);
        for (int n = 0; n < 12; n++) do_line(1'b0);
        chk("R9 overrun set", int'(overrun), 1);
        for (int n = 0; n < DEPTH + 1; n++) pop_chk();
        chk("R10 underrun set", int'(underrun), 1);
        repeat (3) @(negedge clk);
        chk("R11 overrun held", int'(overrun), 1);
        chk("R11 underrun held", int'(underrun), 1);
        start_frame(2, 0);

        done = 1;
        report();
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end
endmodule